// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block sequences one CPU core, and the top logic domain beside it, into and out of a low-power state. It reacts only to a rising edge of the core's wait-for-interrupt signal. At that edge it latches two configuration fields, a standby field and a top-domain field. These fields select one of two modes. In clock-stop mode only the core clock is halted. In core power-off mode the core loses power, with its state held in retention, and the top domain is either powered off, clock-stopped or left running. The audio domain is powered in every mode, so it has no controls here.

Each domain has four outputs: a clock enable, an isolation clamp, a retention request and a power request. A power switch answers each power request with an acknowledge. For a domain that loses power, entry steps through these on successive cycles: clock off, isolation on, retention on, power off. Exit runs the same steps backwards. Before retention is released, exit waits for every power acknowledge and then for a fixed settle time. An enabled wakeup that arrives part way through entry turns the sequence around at the step it has reached. The block marks the end of every exit with a one-cycle completion pulse.

Top module: `lpm_entry_ctrl`

## Requirements
- R1: After reset, both clock enables are 1, isolation and retention are 0, both power requests are 1 and wakeDone is 0. Bit 0 of every per-domain output is the core and bit 1 is the top domain.
- R2: A standby value of 2'b00, 2'b10 or 2'b11 selects clock-stop mode. On the wait-for-interrupt rise, clkEn[0] goes low one cycle later. Every other output keeps its prior value.
- R3: A standby value of 2'b01 selects core power-off mode. On the cycles after the wait-for-interrupt rise, outputs change one step per cycle: cycle 1 clocks off, cycle 2 isolation on, cycle 3 retention on, cycle 4 power requests off. Retention applies to the core only.
- R4: In core power-off mode with a top field of 2'b00, the top domain has its clock stopped, is isolated and loses power. It gets no retention.
- R5: With a top field of 2'b01, only the top domain's clock is stopped. Its isolation, retention and power stay unchanged.
- R6: With a top field of 2'b10 or 2'b11, no output of the top domain changes.
- R7: Entry happens only on a rising edge of wfiIn. Both fields are captured at that edge. Field changes while asleep have no effect on the outputs or on the exit path. A wfiIn still held high after exit does not start a new entry.
- R8: Only a wakeup source whose wakeEn bit is 1 ends the low-power state. A source whose enable is 0 leaves all outputs unchanged.
- R9: Exit from power-off mode starts the cycle after the wake is sampled. Power requests go high first. Once every pwrAck bit is 1, the block waits SETTLE_CYC cycles, then releases retention, then isolation, then the clocks.
- R10: A wake sampled during entry starts the exit from the step reached. Sampled one cycle after the rise, clocks restore on that edge. Sampled two cycles after, isolation clears and then clocks restore one cycle later. Sampled three cycles after, retention, isolation and clocks clear on three successive edges.
- R11: wakeDone is a one-cycle pulse. It is issued on the same edge at which clkEn[0] returns to 1.
- R12: A wakeup while no low-power mode is active has no effect and gives no wakeDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wfiIn | input | 1 | Core wait-for-interrupt indication |
| standbyCfg | input | 2 | Standby mode field, captured on wfiIn rise |
| topCfg | input | 2 | Top-domain option field, captured on wfiIn rise |
| wakeSrc | input | WAKE_N | Raw wakeup sources |
| wakeEn | input | WAKE_N | Per-source wakeup enables |
| pwrAck | input | 2 | Power-good acknowledge per domain |
| clkEn | output | 2 | Clock enable per domain |
| isoEn | output | 2 | Isolation clamp per domain |
| retEn | output | 2 | Retention request per domain |
| pwrOn | output | 2 | Power request per domain |
| wakeDone | output | 1 | One-cycle exit-complete pulse |

## Verification
The entry outputs are due one, two, three and four edges after the edge that samples the wfiIn rise. The bench reads them at the falling edge after each of those edges. For wakeDone, the driver computes the edge on which the pulse is due and queues it. That edge is the wake-sample edge for clock-stop exit. For a full exit it is that edge plus the two-cycle acknowledge delay, plus SETTLE_CYC, plus three. For aborts it is zero, one or two edges later, depending on the step reached. A monitor compares each pulse against the queue, so a pulse that comes early, late, twice or uninvited is reported.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int DOM_N = 2;
  localparam int CORE  = 0;
  localparam int TOP   = 1;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_ENT_ISO,
    ST_ENT_RET,
    ST_ENT_PWR,
    ST_SLEEP,
    ST_EX_PWR,
    ST_EX_SETTLE,
    ST_EX_ISO,
    ST_EX_CLK
  } lpmState_e;

  // one-cycle commands from the sequencer to the output registers
  typedef struct packed {
    logic capture;     // latch mode and stop clocks
    logic isoOn;
    logic retOn;
    logic pwrOff;
    logic pwrUp;
    logic settleLoad;
    logic retOff;
    logic isoOff;
    logic clkOn;       // restore clocks, raise wake-done
  } lpmStrobe_t;

  typedef struct packed {
    logic [DOM_N-1:0] clk;
    logic [DOM_N-1:0] iso;
    logic [DOM_N-1:0] ret;
    logic [DOM_N-1:0] gate;
  } lpmMask_t;

  function automatic lpmMask_t modeMask(logic [1:0] standby, logic [1:0] top);
    lpmMask_t m;
    m = '0;
    m.clk[CORE] = 1'b1;
    if (standby == 2'b01) begin
      m.iso[CORE]  = 1'b1;
      m.ret[CORE]  = 1'b1;
      m.gate[CORE] = 1'b1;
      m.clk[TOP]   = (top == 2'b00) || (top == 2'b01);
      m.iso[TOP]   = (top == 2'b00);
      m.gate[TOP]  = (top == 2'b00);
    end
    return m;
  endfunction

endpackage

// File: rtl/lpm_dpath.sv
module lpm_dpath
  import lpm_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  lpmStrobe_t       stb,
  input  logic [1:0]       standbyCfg,
  input  logic [1:0]       topCfg,
  output logic [DOM_N-1:0] clkEn,
  output logic [DOM_N-1:0] isoEn,
  output logic [DOM_N-1:0] retEn,
  output logic [DOM_N-1:0] pwrOn,
  output logic             wakeDone,
  output logic             deepReq,
  output logic             deepCap,
  output logic             settleDone
);

  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  lpmMask_t         newMask;
  lpmMask_t         capMask;
  logic [CNT_W-1:0] settleCnt;

  assign newMask    = modeMask(standbyCfg, topCfg);
  assign deepReq    = |newMask.gate;
  assign deepCap    = |capMask.gate;
  assign settleDone = (settleCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capMask   <= '0;
      clkEn     <= '1;
      isoEn     <= '0;
      retEn     <= '0;
      pwrOn     <= '1;
      wakeDone  <= 1'b0;
      settleCnt <= '0;
    end else begin
      wakeDone <= stb.clkOn;
      if (stb.capture) begin
        capMask <= newMask;
        clkEn   <= clkEn & ~newMask.clk;
      end
      if (stb.clkOn)  clkEn <= clkEn | capMask.clk;
      if (stb.isoOn)  isoEn <= isoEn | capMask.iso;
      if (stb.isoOff) isoEn <= isoEn & ~capMask.iso;
      if (stb.retOn)  retEn <= retEn | capMask.ret;
      if (stb.retOff) retEn <= retEn & ~capMask.ret;
      if (stb.pwrOff) pwrOn <= pwrOn & ~capMask.gate;
      if (stb.pwrUp)  pwrOn <= pwrOn | capMask.gate;
      if (stb.settleLoad)      settleCnt <= CNT_W'(SETTLE_CYC - 1);
      else if (!settleDone)    settleCnt <= settleCnt - 1'b1;
    end
  end

  // a domain without power must be clamped
  p_iso_guards_power_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((~pwrOn & ~isoEn) == '0));

  // a clamped domain never has a running clock
  p_clk_stopped_under_iso_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((isoEn & clkEn) == '0));

  // retention is only let go while power is requested
  p_ret_release_powered_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(retEn) & ~retEn) & ~pwrOn) == '0));

  p_wake_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    wakeDone |=> !wakeDone);

  p_wake_with_core_clk_r11: assert property (@(posedge clk) disable iff (!rstN)
    wakeDone |-> (clkEn[CORE] && !$past(clkEn[CORE])));

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int WAKE_N = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wfiIn,
  input  logic [WAKE_N-1:0] wakeSrc,
  input  logic [WAKE_N-1:0] wakeEn,
  input  logic [DOM_N-1:0] pwrAck,
  input  logic             deepReq,
  input  logic             deepCap,
  input  logic             settleDone,
  output lpmStrobe_t       stb
);

  lpmState_e state, nxt;
  logic      wfiQ;
  logic      wfiRise;
  logic      wakeHit;
  logic      allUp;

  assign wfiRise = wfiIn & ~wfiQ;
  assign wakeHit = |(wakeSrc & wakeEn);
  assign allUp   = &pwrAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN;
      wfiQ  <= 1'b0;
    end else begin
      state <= nxt;
      wfiQ  <= wfiIn;
    end
  end

  always_comb begin
    stb = '0;
    nxt = state;
    unique case (state)
      ST_RUN: if (wfiRise) begin
        stb.capture = 1'b1;
        nxt = deepReq ? ST_ENT_ISO : ST_SLEEP;
      end
      ST_ENT_ISO: if (wakeHit) begin
        stb.clkOn = 1'b1;      nxt = ST_RUN;
      end else begin
        stb.isoOn = 1'b1;      nxt = ST_ENT_RET;
      end
      ST_ENT_RET: if (wakeHit) begin
        stb.isoOff = 1'b1;     nxt = ST_EX_CLK;
      end else begin
        stb.retOn = 1'b1;      nxt = ST_ENT_PWR;
      end
      ST_ENT_PWR: if (wakeHit) begin
        stb.retOff = 1'b1;     nxt = ST_EX_ISO;
      end else begin
        stb.pwrOff = 1'b1;     nxt = ST_SLEEP;
      end
      ST_SLEEP: if (wakeHit) begin
        if (deepCap) begin
          stb.pwrUp = 1'b1;    nxt = ST_EX_PWR;
        end else begin
          stb.clkOn = 1'b1;    nxt = ST_RUN;
        end
      end
      ST_EX_PWR: if (allUp) begin
        stb.settleLoad = 1'b1; nxt = ST_EX_SETTLE;
      end
      ST_EX_SETTLE: if (settleDone) begin
        stb.retOff = 1'b1;     nxt = ST_EX_ISO;
      end
      ST_EX_ISO: begin
        stb.isoOff = 1'b1;     nxt = ST_EX_CLK;
      end
      ST_EX_CLK: begin
        stb.clkOn = 1'b1;      nxt = ST_RUN;
      end
      default: nxt = ST_RUN;
    endcase
  end

  // settling is only counted with every switch reporting power good
  p_settle_needs_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EX_SETTLE) |-> allUp);

  // leaving the running state needs a fresh wait-for-interrupt edge
  p_entry_on_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_RUN && state != ST_RUN) |-> ($past(wfiIn) && !$past(wfiQ)));

endmodule

// File: rtl/lpm_entry_ctrl.sv
module lpm_entry_ctrl
  import lpm_pkg::*;
#(
  parameter int WAKE_N     = 4,
  parameter int SETTLE_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wfiIn,
  input  logic [1:0]        standbyCfg,
  input  logic [1:0]        topCfg,
  input  logic [WAKE_N-1:0] wakeSrc,
  input  logic [WAKE_N-1:0] wakeEn,
  input  logic [1:0]        pwrAck,
  output logic [1:0]        clkEn,
  output logic [1:0]        isoEn,
  output logic [1:0]        retEn,
  output logic [1:0]        pwrOn,
  output logic              wakeDone
);

  lpmStrobe_t stb;
  logic       deepReq;
  logic       deepCap;
  logic       settleDone;

  lpm_ctrl #(.WAKE_N(WAKE_N)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wfiIn      (wfiIn),
    .wakeSrc    (wakeSrc),
    .wakeEn     (wakeEn),
    .pwrAck     (pwrAck),
    .deepReq    (deepReq),
    .deepCap    (deepCap),
    .settleDone (settleDone),
    .stb        (stb)
  );

  lpm_dpath #(.SETTLE_CYC(SETTLE_CYC)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .standbyCfg (standbyCfg),
    .topCfg     (topCfg),
    .clkEn      (clkEn),
    .isoEn      (isoEn),
    .retEn      (retEn),
    .pwrOn      (pwrOn),
    .wakeDone   (wakeDone),
    .deepReq    (deepReq),
    .deepCap    (deepCap),
    .settleDone (settleDone)
  );

endmodule

// File: tb/lpm_entry_ctrl_bench.sv
module lpm_entry_ctrl_bench;

  localparam int WAKE_N  = 4;
  localparam int SETTLE  = 16;
  localparam int ACK_DLY = 2;
  localparam int FULL_EXIT = ACK_DLY + SETTLE + 3;
  localparam logic [7:0] ALL_ON = 8'b11_00_00_11;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wfiIn = 1'b0;
  logic [1:0]        standbyCfg = 2'b00;
  logic [1:0]        topCfg = 2'b10;
  logic [WAKE_N-1:0] wakeSrc = '0;
  logic [WAKE_N-1:0] wakeEn = '0;
  logic [1:0]        pwrAck;
  logic [1:0]        clkEn, isoEn, retEn, pwrOn;
  logic              wakeDone;
  logic [1:0]        ackQ1, ackQ2;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  int    expQ[$];
  string tagQ[$];
  int    popCyc;
  string popTag;

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // power switch model: acknowledge follows the request after ACK_DLY cycles
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackQ1 <= 2'b11;
      ackQ2 <= 2'b11;
    end else begin
      ackQ1 <= pwrOn;
      ackQ2 <= ackQ1;
    end
  end
  assign pwrAck = ackQ2;

  lpm_entry_ctrl #(.WAKE_N(WAKE_N), .SETTLE_CYC(SETTLE)) u_lpm_entry_ctrl (
    .clk(clk), .rstN(rstN), .wfiIn(wfiIn), .standbyCfg(standbyCfg),
    .topCfg(topCfg), .wakeSrc(wakeSrc), .wakeEn(wakeEn), .pwrAck(pwrAck),
    .clkEn(clkEn), .isoEn(isoEn), .retEn(retEn), .pwrOn(pwrOn),
    .wakeDone(wakeDone)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic snap(string tag, logic [7:0] exp);
    logic [7:0] act;
    act = {clkEn, isoEn, retEn, pwrOn};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs clk_iso_ret_pwr=%b expected %b", tag, act, exp);
    end
  endtask

  // driver: raises an enabled wake for one cycle and queues the due edge
  task automatic wakeExpect(int offset, string tag);
    expQ.push_back(cyc + 1 + offset);
    tagQ.push_back(tag);
    wakeSrc = 4'b0100;
    wakeEn  = 4'b0100;
    tick(1);
    wakeSrc = '0;
  endtask

  task automatic drain();
    for (int g = 0; g < 80 && expQ.size() != 0; g++) tick(1);
    tick(1);
  endtask

  task automatic enter(logic [1:0] sb, logic [1:0] tp);
    standbyCfg = sb;
    topCfg     = tp;
    wfiIn      = 1'b1;
  endtask

  task automatic leave();
    wfiIn = 1'b0;
    tick(2);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: every wake-done pulse is matched against the queue
  always @(negedge clk) begin
    if (rstN && wakeDone === 1'b1) begin
      checks++;
      if (clkEn[0] !== 1'b1) begin
        errors++;
        $display("FAIL R11: clkEn[0]=%b with wakeDone, expected 1", clkEn[0]);
      end
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R12: wakeDone=1 at cycle %0d, expected 0 (none due)", cyc);
      end else begin
        popCyc = expQ.pop_front();
        popTag = tagQ.pop_front();
        if (popCyc != cyc) begin
          errors++;
          $display("FAIL %s: wakeDone at cycle %0d expected %0d", popTag, cyc, popCyc);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    report();
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    snap("R1 reset state", ALL_ON);
    checks++;
    if (wakeDone !== 1'b0) begin
      errors++;
      $display("FAIL R1: wakeDone=%b expected 0", wakeDone);
    end

    // R12: wake while running
    wakeSrc = 4'b1111; wakeEn = 4'b1111;
    tick(3);
    wakeSrc = '0; wakeEn = '0;
    tick(2);
    snap("R12 wake while running", ALL_ON);

    // R2: clock-stop mode, standby 00
    enter(2'b00, 2'b00);
    tick(1);
    snap("R2 idle core clock off", 8'b10_00_00_11);
    tick(3);
    snap("R2 idle holds", 8'b10_00_00_11);
    // R8: source present but not enabled
    wakeSrc = 4'b0010; wakeEn = 4'b0001;
    tick(3);
    wakeSrc = '0; wakeEn = '0;
    snap("R8 disabled wake ignored", 8'b10_00_00_11);
    wakeExpect(0, "R2 idle exit");
    snap("R2 idle restored", ALL_ON);
    tick(4);
    snap("R7 held wfi no reentry", ALL_ON);
    drain();
    leave();

    // R2: reserved standby values behave as clock-stop mode
    for (int v = 2; v < 4; v++) begin
      enter(2'(v), 2'b00);
      tick(2);
      snap("R2 reserved standby", 8'b10_00_00_11);
      wakeExpect(0, "R2 reserved exit");
      drain();
      leave();
    end

    // R3 / R4: power-off mode with top domain powered off
    enter(2'b01, 2'b00);
    tick(1);
    snap("R3 step1 clocks", 8'b00_00_00_11);
    tick(1);
    snap("R3 step2 isolation", 8'b00_11_00_11);
    tick(1);
    snap("R3 step3 retention", 8'b00_11_01_11);
    tick(1);
    snap("R4 step4 power off", 8'b00_11_01_00);
    // R7: field writes while asleep are ignored
    standbyCfg = 2'b00; topCfg = 2'b10;
    tick(3);
    snap("R7 config change asleep", 8'b00_11_01_00);
    wakeExpect(FULL_EXIT, "R9 full exit latency");
    snap("R9 power first", 8'b00_11_01_11);
    tick(ACK_DLY + SETTLE - 1);
    snap("R9 retention held in settle", 8'b00_11_01_11);
    drain();
    snap("R9 exit complete", ALL_ON);
    leave();

    // R5: top clock only
    enter(2'b01, 2'b01);
    tick(6);
    snap("R5 top clock only", 8'b00_01_01_10);
    wakeExpect(FULL_EXIT, "R5 exit");
    drain();
    snap("R5 restored", ALL_ON);
    leave();

    // R6: top running, both encodings
    for (int v = 2; v < 4; v++) begin
      enter(2'b01, 2'(v));
      tick(6);
      snap("R6 top untouched", 8'b10_01_01_10);
      wakeExpect(FULL_EXIT, "R6 exit");
      drain();
      leave();
    end

    // R10: aborts at each entry step
    enter(2'b01, 2'b00);
    tick(1);
    wakeExpect(0, "R10 abort at step2");
    snap("R10 abort step2 state", ALL_ON);
    drain();
    leave();

    enter(2'b01, 2'b00);
    tick(2);
    wakeExpect(1, "R10 abort at step3");
    snap("R10 abort step3 iso cleared", 8'b00_00_00_11);
    drain();
    leave();

    enter(2'b01, 2'b00);
    tick(3);
    wakeExpect(2, "R10 abort at step4");
    snap("R10 abort step4 ret cleared", 8'b00_11_00_11);
    drain();
    snap("R10 abort step4 restored", ALL_ON);
    leave();

    tick(4);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R11: %0d wake-done pulses missing, expected 0", expQ.size());
    end
    report();
  end

endmodule